// File: doc/BRIEF.md
# Parity-Appending Serial Shifter

This block accepts one 8-bit byte, adds a parity bit to it, and sends the resulting 9-bit frame out on a single serial line, one bit per enabled cycle of a clock that never stops. Two strobes that are synchronous to the clock control it. A load strobe captures a new byte and its parity. A shift-enable strobe moves the frame on by one bit. When neither strobe is active, the frame in flight stays where it is.

The parity sense depends on the line's idle level, so that a byte equal to the idle pattern still makes the parity bit differ from the idle level. A line that idles low (active-high signalling, idle byte 0x00) uses odd parity. A line that idles high (active-low signalling, idle byte 0xFF) uses even parity. When no frame is in flight, the serial output sits at the idle level. A one-cycle done pulse marks the end of each frame.

Top module: `psr_serializer`

## Requirements
- R1: With `idle_high_i` = 0, the parity bit is odd parity: it is 1 exactly when the captured byte holds an even number of ones, so byte 0x00 gives a parity bit of 1.
- R2: With `idle_high_i` = 1, the parity bit is even parity: it is 1 exactly when the captured byte holds an odd number of ones, so byte 0xFF gives a parity bit of 0.
- R3: After a load, `ser_o` shows data bit 0 first. Each cycle that has `shift_en_i` high and no load advances the output one bit, through data bits 1 to 7 and then the parity bit as the ninth and last bit.
- R4: In a cycle where both `load_i` and `shift_en_i` are low, the frame in flight and `ser_o` stay unchanged.
- R5: When `load_i` and `shift_en_i` are high in the same cycle, the load wins. The new frame starts from its bit 0, and this applies even while an earlier frame is still in flight.
- R6: While no frame is in flight, `ser_o` equals `idle_high_i`.
- R7: `done_o` is high for exactly one cycle. That cycle follows the shift that retires the ninth bit, and at the same time `busy_o` falls.
- R8: The parity sense is taken from `idle_high_i` in the load cycle. A later change of `idle_high_i` does not alter the parity bit of the frame already loaded.
- R9: After reset, `busy_o` = 0, `done_o` = 0, and `ser_o` follows the idle level.
- R10: A shift-enable strobe with no frame in flight has no effect: `busy_o` stays low, `done_o` stays low and `ser_o` stays at the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| idle_high_i | input | 1 | Line idle level: 1 idles high (even parity), 0 idles low (odd parity) |
| load_i | input | 1 | Capture `data_i` and its parity as a new frame |
| shift_en_i | input | 1 | Advance the frame in flight by one bit |
| data_i | input | 8 | Byte to be sent |
| ser_o | output | 1 | Serial output line |
| busy_o | output | 1 | A frame is in flight |
| done_o | output | 1 | One-cycle pulse after the final bit is retired |

## Verification
The bench goes after the idle-pattern bytes 0x00 and 0xFF under each parity sense. A design with the parity sense reversed would put the idle level on the ninth bit, and the comparison would catch it. It sets load and shift-enable in the same cycle, both on an empty register and in the middle of a frame. A design that gave shift-enable priority would drop bit 0 or keep the old frame. It also holds a frame for several cycles, which catches a design that shifts on idle cycles and so loses bits. It flips the idle select in the middle of a frame, so a design that computes parity from the live input instead of at load time sends the wrong ninth bit. Finally, it pulses shift-enable on an empty register, which catches a counter that wraps round and fakes a new frame or a second done pulse.

// File: rtl/psr_pkg.sv
// Package: shared constants and types for the parity-appending serializer.
// Assumes: one parity bit per byte, so the frame holds one bit more than the data.
package psr_pkg;
    localparam int DEF_DATA_W = 8;

    // Line idle level, which also selects the parity sense.
    typedef enum logic {
        LINE_IDLE_LOW  = 1'b0,   // active-high line -> odd parity
        LINE_IDLE_HIGH = 1'b1    // active-low line  -> even parity
    } idle_lvl_e;
endpackage

// File: rtl/psr_parity_gen.sv
// Module: combinational parity generator.
// Produces the bit appended to the byte. Odd parity is used when the line
// idles low and even parity when it idles high, so an idle-pattern byte
// always yields a parity bit that differs from the idle level.
// Assumes: the caller samples the result in the load cycle.
module psr_parity_gen
    import psr_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic [DATA_W-1:0] data_i,
    input  idle_lvl_e         idle_lvl_i,
    output logic              par_o
);
    logic xor_all;

    // Reduce the byte, then invert for odd parity on an idle-low line.
    always_comb begin
        xor_all = ^data_i;
        par_o   = (idle_lvl_i == LINE_IDLE_HIGH) ? xor_all : ~xor_all;
    end
endmodule

// File: rtl/psr_piso.sv
// Module: parallel-in serial-out register with load, shift and hold modes.
// Load has priority over shift. When neither is active the register holds.
// Bit 0 is the next bit on the line, and zeros fill in from the top.
// Assumes: the controls are synchronous to clk, and the caller qualifies
// the shift strobe (no shift when the register is empty).
module psr_piso #(
    parameter int FRAME_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               shift_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic               head_o
);
    logic [FRAME_W-1:0] sreg_q;

    // Register update: load, else shift right, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (load_i) begin
            sreg_q <= frame_i;
        end else if (shift_i) begin
            sreg_q <= {1'b0, sreg_q[FRAME_W-1:1]};
        end
    end

    // Expose the current output bit.
    always_comb head_o = sreg_q[0];
endmodule

// File: rtl/psr_bit_cnt.sv
// Module: count of bits remaining, with the busy and done indications.
// Load sets the count to the frame length. Each qualified shift takes one off.
// Done is a registered one-cycle pulse that follows the shift that empties
// the frame, unless a load in the same cycle overrides that shift.
module psr_bit_cnt #(
    parameter int FRAME_W = 9,
    localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic shift_en_i,
    output logic shift_o,
    output logic busy_o,
    output logic done_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    // A shift counts only with a frame in flight and no load competing.
    always_comb begin
        busy_o  = (cnt_q != '0);
        shift_o = shift_en_i && busy_o && !load_i;
        done_o  = done_q;
    end

    // Track the bits remaining.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= FULL;
        end else if (shift_o) begin
            cnt_q <= cnt_q - LAST;
        end
    end

    // Pulse done for one cycle after the final bit is retired.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= shift_o && (cnt_q == LAST);
        end
    end
endmodule

// File: rtl/psr_serializer.sv
// Module: top level of the parity-appending serial shifter.
// Captures a byte with its parity on load_i and sends the 9-bit frame LSB
// first, with the parity bit last, one bit per shift_en_i cycle. With no
// frame in flight, the line rests at the idle level given by idle_high_i.
// Assumes: a free-running clk, strobes synchronous to clk, and a synchronous
// active-low reset.
module psr_serializer
    import psr_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    localparam int FRAME_W = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle_high_i,
    input  logic              load_i,
    input  logic              shift_en_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              ser_o,
    output logic              busy_o,
    output logic              done_o
);
    idle_lvl_e          idle_lvl;
    logic               par_bit;
    logic [FRAME_W-1:0] frame;
    logic               shift_ok;
    logic               head_bit;

    // Decode the idle select and assemble the frame (parity at the top).
    always_comb begin
        idle_lvl = idle_high_i ? LINE_IDLE_HIGH : LINE_IDLE_LOW;
        frame    = {par_bit, data_i};
    end

    psr_parity_gen #(.DATA_W(DATA_W)) par_i (
        .data_i     (data_i),
        .idle_lvl_i (idle_lvl),
        .par_o      (par_bit)
    );

    psr_bit_cnt #(.FRAME_W(FRAME_W)) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .shift_en_i (shift_en_i),
        .shift_o    (shift_ok),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    psr_piso #(.FRAME_W(FRAME_W)) sreg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .shift_i (shift_ok),
        .frame_i (frame),
        .head_o  (head_bit)
    );

    // Drive the line: frame bit while busy, idle level otherwise.
    always_comb ser_o = busy_o ? head_bit : idle_high_i;
endmodule

// File: rtl/psr_serializer_chk.sv
// Checker: port-level properties of psr_serializer, bound to every instance.
module psr_serializer_chk (
    input logic clk,
    input logic rst_n,
    input logic idle_high_i,
    input logic load_i,
    input logic shift_en_i,
    input logic ser_o,
    input logic busy_o,
    input logic done_o
);
    // R7: done never lasts two cycles.
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: done comes with busy low.
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R4: with no strobe, a frame in flight keeps its output bit.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !load_i && !shift_en_i) |=> (busy_o && $stable(ser_o)));

    // R5: a load always starts a frame.
    p_load_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (busy_o && !done_o));

    // R6: with nothing in flight the line shows the idle level.
    p_idle_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (ser_o == idle_high_i));

    // R10: without a load, an empty register stays empty.
    p_empty_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !load_i) |=> (!busy_o && !done_o));
endmodule

bind psr_serializer psr_serializer_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle_high_i (idle_high_i),
    .load_i      (load_i),
    .shift_en_i  (shift_en_i),
    .ser_o       (ser_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/psr_serializer_tb_top.sv
// Bench: behavioural queue model of the serial line, compared every cycle.
module psr_serializer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idle_high = 1'b0;
    logic       load = 1'b0;
    logic       shift_en = 1'b0;
    logic [7:0] data = 8'h00;
    logic       ser, busy, done;

    int checks = 0;
    int errors = 0;
    bit q[$];
    bit done_m = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    psr_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .idle_high_i(idle_high), .load_i(load),
        .shift_en_i(shift_en), .data_i(data),
        .ser_o(ser), .busy_o(busy), .done_o(done)
    );

    // Expected parity from the requirements: odd sense (R1) or even sense (R2).
    function automatic bit exp_par(input logic [7:0] d, input logic idl);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += d[i];
        return idl ? bit'(ones % 2 == 1) : bit'(ones % 2 == 0);
    endfunction

    task automatic check(input string tag);
        bit e_ser  = (q.size() > 0) ? q[0] : idle_high;
        bit e_busy = (q.size() > 0);
        checks++;
        if (ser !== e_ser || busy !== e_busy || done !== done_m) begin
            errors++;
            $display("FAIL %s: ser/busy/done actual %b%b%b expected %b%b%b",
                     tag, ser, busy, done, e_ser, e_busy, done_m);
        end
    endtask

    // Drive one cycle, advance the model, then check after the edge.
    task automatic cyc(input logic ld, input logic en, input logic [7:0] d,
                       input logic idl, input string tag);
        load = ld; shift_en = en; data = d; idle_high = idl;
        done_m = 1'b0;
        if (ld) begin
            q.delete();
            for (int i = 0; i < 8; i++) q.push_back(d[i]);
            q.push_back(exp_par(d, idl));
        end else if (en && q.size() > 0) begin
            void'(q.pop_front());
            if (q.size() == 0) done_m = 1'b1;
        end
        @(negedge clk);
        check(tag);
    endtask

    task automatic send(input logic [7:0] d, input logic idl, input string tag);
        cyc(1, 0, d, idl, tag);
        for (int i = 0; i < 10; i++) cyc(0, 1, 8'h00, idl, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset");
        rst_n = 1'b1;
        cyc(0, 0, 8'h00, 0, "R9 after reset");
        // R1: odd parity on an idle-low line.
        send(8'h00, 0, "R1 0x00 odd");
        send(8'h01, 0, "R1 0x01 odd");
        send(8'hA5, 0, "R3 0xA5 order");
        // R2: even parity on an idle-high line.
        send(8'hFF, 1, "R2 0xFF even");
        send(8'h7F, 1, "R2 0x7F even");
        cyc(0, 0, 8'h00, 1, "R6 idle high rest");
        // R4: hold in the middle of a frame.
        cyc(1, 0, 8'h3C, 0, "R4 load");
        for (int i = 0; i < 3; i++) cyc(0, 1, 8'h00, 0, "R4 shift");
        for (int i = 0; i < 4; i++) cyc(0, 0, 8'hFF, 0, "R4 hold");
        for (int i = 0; i < 7; i++) cyc(0, 1, 8'h00, 0, "R4 finish");
        // R5: load beats shift on an empty register and during a frame.
        cyc(1, 1, 8'h96, 0, "R5 load+en empty");
        for (int i = 0; i < 4; i++) cyc(0, 1, 8'h00, 0, "R5 shift");
        cyc(1, 1, 8'h5A, 1, "R5 load+en busy");
        for (int i = 0; i < 8; i++) cyc(0, 1, 8'h00, 1, "R5 shift");
        cyc(1, 1, 8'hC3, 1, "R5 load on last shift");
        for (int i = 0; i < 10; i++) cyc(0, 1, 8'h00, 1, "R5 drain");
        // R8: idle select changes in the middle of a frame.
        cyc(1, 0, 8'h00, 0, "R8 load");
        for (int i = 0; i < 5; i++) cyc(0, 1, 8'h00, 1, "R8 flip");
        for (int i = 0; i < 5; i++) cyc(0, 1, 8'h00, 0, "R8 flip back");
        cyc(1, 0, 8'hFF, 1, "R8 load");
        for (int i = 0; i < 10; i++) cyc(0, 1, 8'h00, 0, "R8 flip");
        // R10: shift strobes with nothing in flight.
        for (int i = 0; i < 4; i++) cyc(0, 1, 8'h00, 1, "R10 en empty");
        for (int i = 0; i < 4; i++) cyc(0, 1, 8'h00, 0, "R10 R6 en empty");
        // R7: done spacing with gaps between shifts.
        cyc(1, 0, 8'h81, 0, "R7 load");
        for (int i = 0; i < 9; i++) begin
            cyc(0, 1, 8'h00, 0, "R7 shift");
            cyc(0, 0, 8'h00, 0, "R7 gap");
        end
        cyc(0, 0, 8'h00, 0, "R7 after");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule